// File: doc/BRIEF.md
# Dual-Clock Port Mailbox Controller

This block is the control layer between two independent ports, A and B, which run on unrelated clocks. Each port has four controls: an active-low select, a direction select (high means read), an enable and a mailbox-path select. From these the block works out which action the port asks for in the current cycle. The FIFO storage that acts on FIFO reads and writes lives outside this block; the decoded action code is passed to it. The block also gives each port an output-drive enable for its pad buffers.

The block also holds two one-word mailboxes that bypass the FIFO. Port A writes the first mailbox and port B reads it. Port B writes the second mailbox and port A reads it. Each mailbox has a status flag in the reader's clock domain. The flag is high when the mailbox is empty and low when a message is waiting. Writes and reads are signalled across the clock boundary by toggle events passed through two-flop synchronizers, so no event is dropped. The writer's data register does not change until the reader's acknowledgement comes back, which makes the word safe to capture in the reader's domain.

Top module: `dual_mailbox_ctrl`

## Requirements
- R1: While a port's select input is high, its action code is 0 (no action), whatever its other controls are.
- R2: A port's output-drive enable is high exactly when its select is low and its direction input is high; the enable input has no influence on it.
- R3: With select low and enable high, the action code is 1 for FIFO write (mailbox-path 0, direction 0), 2 for FIFO read (0, 1), 3 for mailbox write (1, 0) and 4 for mailbox read (1, 1). With enable low it is 0, and a mailbox request held with enable low changes no flag.
- R4: After a mailbox write on port A, port B's flag stays high for the first two port B rising edges that follow the write edge, and goes low within the next four port B edges.
- R5: A mailbox read while the reader's flag is low sets the flag high at that edge, and from that edge the reader's data output holds the word that was written.
- R6: A mailbox write made while the previous message in that mailbox is still unread is ignored; the reader later gets the first word, and no new message is signalled.
- R7: Consecutive messages, each written after the previous one has been read and acknowledged, all arrive in order with their exact values.
- R8: A mailbox read while the reader's flag is high leaves the reader's data output unchanged and the flag high.
- R9: After reset both flags are high, both data outputs are zero and both action codes are 0 while the selects are high.
- R10: The B-to-A mailbox behaves the same way as the A-to-B mailbox, independently of it: traffic in one direction does not change the other direction's flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| a_sel_n | input | 1 | Port A select, active low |
| a_rd | input | 1 | Port A direction, 1 = read |
| a_en | input | 1 | Port A enable |
| a_mbx | input | 1 | Port A mailbox-path select |
| a_din | input | DW | Word written to the A-to-B mailbox |
| a_dout | output | DW | Last word read by port A from the B-to-A mailbox |
| a_oe | output | 1 | Port A output-drive enable |
| a_act | output | 3 | Port A decoded action code |
| a_mbx_empty | output | 1 | B-to-A mailbox flag in port A domain, 1 = empty |
| b_sel_n | input | 1 | Port B select, active low |
| b_rd | input | 1 | Port B direction, 1 = read |
| b_en | input | 1 | Port B enable |
| b_mbx | input | 1 | Port B mailbox-path select |
| b_din | input | DW | Word written to the B-to-A mailbox |
| b_dout | output | DW | Last word read by port B from the A-to-B mailbox |
| b_oe | output | 1 | Port B output-drive enable |
| b_act | output | 3 | Port B decoded action code |
| b_mbx_empty | output | 1 | A-to-B mailbox flag in port B domain, 1 = empty |

## Verification
Some rules are checked by assertions on every clock of their domain: a deselected port never reports an action, the drive enable appears only under select-low and read, a write against an unread mailbox leaves the stored word and the event toggle unchanged, a read of a full mailbox frees it, and a read of an empty mailbox leaves the output alone. Other behaviour can only be shown by the bench's scenarios: the flag latency across the clock boundary, the word that finally comes out on the far port, the order of a stream of messages, and the independence of the two directions.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  typedef enum logic [2:0] {
    ACT_NONE = 3'd0,
    ACT_FWR  = 3'd1,
    ACT_FRD  = 3'd2,
    ACT_MWR  = 3'd3,
    ACT_MRD  = 3'd4
  } port_act_e;
endpackage

// File: rtl/cdc_sync.sv
// Multi-stage synchronizer; also used as reset release synchronizer.
module cdc_sync #(
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= {STAGES{RST_VAL}};
    else        sh_q <= sh_d;
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/port_decode.sv
// Per-port control decode: action code and output-drive enable.
module port_decode
  import mbox_pkg::*;
(
  input  logic      sel_n,
  input  logic      rd,
  input  logic      en,
  input  logic      mbx,
  output port_act_e act,
  output logic      oe
);
  always_comb begin
    act = ACT_NONE;
    if (!sel_n && en) begin
      unique case ({mbx, rd})
        2'b00:   act = ACT_FWR;
        2'b01:   act = ACT_FRD;
        2'b10:   act = ACT_MWR;
        default: act = ACT_MRD;
      endcase
    end
    oe = !sel_n && rd;
  end
endmodule

// File: rtl/mbox_tx.sv
// Writer side of one mailbox: holds the word until the reader acknowledges.
module mbox_tx #(
  parameter int unsigned DW   = 36,
  parameter int unsigned SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_req,
  input  logic [DW-1:0] wdata,
  input  logic          ack_tgl,
  output logic          send_tgl,
  output logic [DW-1:0] data_q
);
  logic          ack_s;
  logic          ack_seen_q, ack_seen_d;
  logic          pend_q, pend_d;
  logic          send_d;
  logic [DW-1:0] data_d;
  logic          accept, ack_hit;

  cdc_sync #(.STAGES(SYNC), .RST_VAL(1'b0)) u_ack_sync (
    .clk(clk), .rst_n(rst_n), .d(ack_tgl), .q(ack_s)
  );

  always_comb begin
    ack_hit    = ack_s ^ ack_seen_q;
    accept     = wr_req && !pend_q;
    ack_seen_d = ack_s;
    pend_d     = pend_q;
    send_d     = send_tgl;
    data_d     = data_q;
    if (accept) begin
      pend_d = 1'b1;
      send_d = ~send_tgl;
      data_d = wdata;
    end else if (ack_hit) begin
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_seen_q <= 1'b0;
      pend_q     <= 1'b0;
      send_tgl   <= 1'b0;
      data_q     <= '0;
    end else begin
      ack_seen_q <= ack_seen_d;
      pend_q     <= pend_d;
      send_tgl   <= send_d;
      if (accept) data_q <= data_d;
    end
  end

  // R6: a write against an unread message changes neither word nor event
  a_r6_hold_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && pend_q) |=> ($stable(data_q) && $stable(send_tgl)));
endmodule

// File: rtl/mbox_rx.sv
// Reader side of one mailbox: flag, output word and acknowledge toggle.
module mbox_rx #(
  parameter int unsigned DW   = 36,
  parameter int unsigned SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          send_tgl,
  input  logic [DW-1:0] mb_data,
  input  logic          rd_req,
  output logic          empty_q,
  output logic [DW-1:0] dout_q,
  output logic          ack_tgl
);
  logic          send_s;
  logic          seen_q, seen_d;
  logic          empty_d, ack_d;
  logic [DW-1:0] dout_d;
  logic          arrive, take;

  cdc_sync #(.STAGES(SYNC), .RST_VAL(1'b0)) u_send_sync (
    .clk(clk), .rst_n(rst_n), .d(send_tgl), .q(send_s)
  );

  always_comb begin
    arrive  = send_s ^ seen_q;
    take    = rd_req && !empty_q && !arrive;
    seen_d  = send_s;
    empty_d = empty_q;
    dout_d  = dout_q;
    ack_d   = ack_tgl;
    if (arrive) begin
      empty_d = 1'b0;
    end else if (take) begin
      empty_d = 1'b1;
      dout_d  = mb_data;
      ack_d   = ~ack_tgl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q  <= 1'b0;
      empty_q <= 1'b1;
      dout_q  <= '0;
      ack_tgl <= 1'b0;
    end else begin
      seen_q  <= seen_d;
      empty_q <= empty_d;
      ack_tgl <= ack_d;
      if (take) dout_q <= dout_d;
    end
  end

  // R5: reading a waiting message frees the mailbox
  a_r5_read_frees: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !empty_q) |=> empty_q);
  // R8: reading an empty mailbox keeps the output word and the flag
  a_r8_empty_read_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && empty_q && !arrive) |=> ($stable(dout_q) && empty_q));
endmodule

// File: rtl/dual_mailbox_ctrl.sv
// Two-port control decode plus two cross-clock mailboxes.
// Index 0 = port A, index 1 = port B; mailbox g is written by port g.
module dual_mailbox_ctrl
  import mbox_pkg::*;
#(
  parameter int unsigned DW   = 36,
  parameter int unsigned SYNC = 2
) (
  input  logic          clk_a,
  input  logic          clk_b,
  input  logic          rst_n,
  input  logic          a_sel_n,
  input  logic          a_rd,
  input  logic          a_en,
  input  logic          a_mbx,
  input  logic [DW-1:0] a_din,
  output logic [DW-1:0] a_dout,
  output logic          a_oe,
  output logic [2:0]    a_act,
  output logic          a_mbx_empty,
  input  logic          b_sel_n,
  input  logic          b_rd,
  input  logic          b_en,
  input  logic          b_mbx,
  input  logic [DW-1:0] b_din,
  output logic [DW-1:0] b_dout,
  output logic          b_oe,
  output logic [2:0]    b_act,
  output logic          b_mbx_empty
);
  localparam int unsigned NPORT = 2;

  logic [NPORT-1:0] clk_v, rst_v, sel_v, rd_v, en_v, mbx_v, oe_v;
  logic [NPORT-1:0] wr_req_v, rd_req_v, send_v, ack_v, empty_v;
  logic [DW-1:0]    din_v   [NPORT];
  logic [DW-1:0]    mbdat_v [NPORT];
  logic [DW-1:0]    rdat_v  [NPORT];
  port_act_e        act_v   [NPORT];

  assign clk_v = {clk_b, clk_a};
  assign sel_v = {b_sel_n, a_sel_n};
  assign rd_v  = {b_rd, a_rd};
  assign en_v  = {b_en, a_en};
  assign mbx_v = {b_mbx, a_mbx};
  assign din_v[0] = a_din;
  assign din_v[1] = b_din;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    localparam int unsigned OTHER = NPORT - 1 - p;

    cdc_sync #(.STAGES(SYNC), .RST_VAL(1'b0)) u_rst_sync (
      .clk(clk_v[p]), .rst_n(rst_n), .d(1'b1), .q(rst_v[p])
    );

    port_decode u_dec (
      .sel_n(sel_v[p]), .rd(rd_v[p]), .en(en_v[p]), .mbx(mbx_v[p]),
      .act(act_v[p]), .oe(oe_v[p])
    );

    assign wr_req_v[p] = (act_v[p] == ACT_MWR);
    assign rd_req_v[p] = (act_v[p] == ACT_MRD);

    // mailbox p: written by port p, read by the other port
    mbox_tx #(.DW(DW), .SYNC(SYNC)) u_tx (
      .clk(clk_v[p]), .rst_n(rst_v[p]), .wr_req(wr_req_v[p]),
      .wdata(din_v[p]), .ack_tgl(ack_v[p]), .send_tgl(send_v[p]),
      .data_q(mbdat_v[p])
    );

    mbox_rx #(.DW(DW), .SYNC(SYNC)) u_rx (
      .clk(clk_v[OTHER]), .rst_n(rst_v[OTHER]), .send_tgl(send_v[p]),
      .mb_data(mbdat_v[p]), .rd_req(rd_req_v[OTHER]), .empty_q(empty_v[p]),
      .dout_q(rdat_v[p]), .ack_tgl(ack_v[p])
    );

    // R1: a deselected port reports no action
    a_r1_sel_idle: assert property (@(posedge clk_v[p]) disable iff (!rst_v[p])
      sel_v[p] |-> (act_v[p] == ACT_NONE));
    // R2: drive enable only when selected and reading
    a_r2_oe_gate: assert property (@(posedge clk_v[p]) disable iff (!rst_v[p])
      oe_v[p] |-> (!sel_v[p] && rd_v[p]));
  end

  assign a_act       = act_v[0];
  assign b_act       = act_v[1];
  assign a_oe        = oe_v[0];
  assign b_oe        = oe_v[1];
  assign a_dout      = rdat_v[1];
  assign b_dout      = rdat_v[0];
  assign a_mbx_empty = empty_v[1];
  assign b_mbx_empty = empty_v[0];
endmodule

// File: tb/dual_mailbox_ctrl_tb.sv
module dual_mailbox_ctrl_tb_top;
  localparam int DW = 36;

  logic clk_a = 1'b0, clk_b = 1'b0, rst_n;
  logic a_sel_n, a_rd, a_en, a_mbx, b_sel_n, b_rd, b_en, b_mbx;
  logic [DW-1:0] a_din, b_din, a_dout, b_dout;
  logic a_oe, b_oe, a_mbx_empty, b_mbx_empty;
  logic [2:0] a_act, b_act;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk_a = ~clk_a;
  always #15 clk_b = ~clk_b;

  dual_mailbox_ctrl #(.DW(DW), .SYNC(2)) dut_i (
    .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n),
    .a_sel_n(a_sel_n), .a_rd(a_rd), .a_en(a_en), .a_mbx(a_mbx),
    .a_din(a_din), .a_dout(a_dout), .a_oe(a_oe), .a_act(a_act),
    .a_mbx_empty(a_mbx_empty),
    .b_sel_n(b_sel_n), .b_rd(b_rd), .b_en(b_en), .b_mbx(b_mbx),
    .b_din(b_din), .b_dout(b_dout), .b_oe(b_oe), .b_act(b_act),
    .b_mbx_empty(b_mbx_empty)
  );

  function automatic logic [2:0] exp_act(logic s, logic r, logic e, logic m);
    if (s || !e) return 3'd0;
    if (!m) return r ? 3'd2 : 3'd1;
    return r ? 3'd4 : 3'd3;
  endfunction

  task automatic check(string req, logic [63:0] actual, logic [63:0] expected);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
    end
  endtask

  task automatic idle_all();
    a_sel_n = 1; a_rd = 0; a_en = 0; a_mbx = 0;
    b_sel_n = 1; b_rd = 0; b_en = 0; b_mbx = 0;
  endtask

  task automatic do_reset();
    idle_all();
    rst_n = 0;
    repeat (3) @(posedge clk_b);
    @(negedge clk_a);
    rst_n = 1;
    repeat (5) @(posedge clk_b);
    repeat (5) @(posedge clk_a);
  endtask

  task automatic mb_op(bit port_b, bit read, logic [DW-1:0] data);
    if (!port_b) begin
      @(negedge clk_a);
      a_sel_n = 0; a_en = 1; a_mbx = 1; a_rd = read; a_din = data;
      @(posedge clk_a); #1;
      a_sel_n = 1; a_en = 0; a_mbx = 0; a_rd = 0;
    end else begin
      @(negedge clk_b);
      b_sel_n = 0; b_en = 1; b_mbx = 1; b_rd = read; b_din = data;
      @(posedge clk_b); #1;
      b_sel_n = 1; b_en = 0; b_mbx = 0; b_rd = 0;
    end
  endtask

  // polls the flag of the reading port; returns edges waited, or -1
  task automatic wait_full(bit port_b, int maxe, output int n);
    n = -1;
    for (int i = 1; i <= maxe; i++) begin
      if (port_b) begin
        @(posedge clk_b); #1;
        if (b_mbx_empty == 1'b0) begin n = i; break; end
      end else begin
        @(posedge clk_a); #1;
        if (a_mbx_empty == 1'b0) begin n = i; break; end
      end
    end
  endtask

  initial begin
    #3000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n;
    logic [DW-1:0] w1, w2, v;
    void'($urandom(32'h5a17));
    a_din = '0; b_din = '0;
    do_reset();

    // R9 reset state
    #1;
    check("R9 a flag", a_mbx_empty, 1);
    check("R9 b flag", b_mbx_empty, 1);
    check("R9 a dout", a_dout, 0);
    check("R9 b dout", b_dout, 0);
    check("R9 a act", a_act, 0);
    check("R9 b act", b_act, 0);

    // R1 R2 R3 random decode on both ports
    for (int i = 0; i < 300; i++) begin
      logic [3:0] ra, rb;
      ra = 4'($urandom); rb = 4'($urandom);
      @(negedge clk_a);
      {a_sel_n, a_rd, a_en, a_mbx} = ra;
      {b_sel_n, b_rd, b_en, b_mbx} = rb;
      #1;
      check("R1/R3 a act", a_act, exp_act(ra[3], ra[2], ra[1], ra[0]));
      check("R1/R3 b act", b_act, exp_act(rb[3], rb[2], rb[1], rb[0]));
      check("R2 a oe", a_oe, !ra[3] && ra[2]);
      check("R2 b oe", b_oe, !rb[3] && rb[2]);
    end
    do_reset();

    // R2 directed: enable low does not gate the drive enable
    @(negedge clk_a);
    a_sel_n = 0; a_rd = 1; a_en = 0; a_mbx = 1; #1;
    check("R2 oe with en low", a_oe, 1);
    check("R3 act with en low", a_act, 0);
    // R3: mailbox write held with enable low while select wiggles
    a_rd = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_a); a_sel_n = i[0];
    end
    idle_all();
    repeat (8) @(posedge clk_b); #1;
    check("R3 en low no mailbox event", b_mbx_empty, 1);

    // R4 latency of the A-to-B flag
    w1 = {4'h9, 32'h1234_5678};
    mb_op(0, 0, w1);
    repeat (2) @(posedge clk_b); #1;
    check("R4 flag still high two edges", b_mbx_empty, 1);
    wait_full(1, 4, n);
    check("R4 flag low within window", n > 0, 1);
    check("R10 other flag untouched", a_mbx_empty, 1);

    // R6 second write against unread message
    w2 = {4'h3, 32'hAAAA_5555};
    mb_op(0, 0, w2);
    // R5 read returns first word and frees mailbox
    mb_op(1, 1, '0);
    check("R5 flag high after read", b_mbx_empty, 1);
    check("R5/R6 read word", b_dout, w1);
    repeat (12) @(posedge clk_b); #1;
    check("R6 ignored write not signalled", b_mbx_empty, 1);

    // R8 empty read
    mb_op(1, 1, '0);
    check("R8 dout unchanged", b_dout, w1);
    check("R8 flag high", b_mbx_empty, 1);
    repeat (8) @(posedge clk_a);

    // R7 stream of messages A to B
    for (int k = 0; k < 6; k++) begin
      v = {4'($urandom), 32'($urandom)};
      mb_op(0, 0, v);
      wait_full(1, 8, n);
      check("R7 message signalled", n > 0, 1);
      mb_op(1, 1, '0);
      check("R7 message value", b_dout, v);
      repeat (8) @(posedge clk_a);
    end

    // R10 B to A direction
    for (int k = 0; k < 4; k++) begin
      v = {4'($urandom), 32'($urandom)};
      mb_op(1, 0, v);
      wait_full(0, 8, n);
      check("R10 B-to-A signalled", n > 0, 1);
      check("R10 A-to-B flag untouched", b_mbx_empty, 1);
      mb_op(0, 1, '0);
      check("R10 B-to-A value", a_dout, v);
      check("R10 flag freed", a_mbx_empty, 1);
      repeat (8) @(posedge clk_b);
    end

    // R10 both directions concurrently
    w1 = 36'h0_0F0F_0F0F; w2 = 36'hF_F0F0_1234;
    fork
      mb_op(0, 0, w1);
      mb_op(1, 0, w2);
    join
    repeat (8) @(posedge clk_b); #1;
    check("R10 both full b", b_mbx_empty, 0);
    check("R10 both full a", a_mbx_empty, 0);
    fork
      mb_op(0, 1, '0);
      mb_op(1, 1, '0);
    join
    check("R10 concurrent a word", a_dout, w2);
    check("R10 concurrent b word", b_dout, w1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule